// File: doc/BRIEF.md
# Power-Managed Mode Sequencer

This block decides whether a small processor core is running, idling or sleeping, and when it comes back. In run mode the CPU clock is on. A sleep-instruction strobe takes the core to one of two low-power states. With the idle-enable bit set, the core goes to idle: the CPU clock stops and the peripherals keep running from the internal oscillator multiplexer. With the idle-enable bit clear, the core goes to sleep and every clock stops.

An enabled interrupt or a watchdog time-out ends either state and starts a fixed exit delay. During the delay the peripherals run from the internal source. At the end the CPU clock returns with a one-cycle resume strobe. A branch-to-vector flag goes with the strobe when the wake came from an interrupt while the global interrupt enable was set. Reset ends everything at once. The primary and internal oscillators are modelled as enable/ready pairs, and each ready flag is timed by its own down-counter.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and right after it, the block is in run mode: CPU and peripheral clock enables are 1, the primary oscillator enable follows R5, and pri_ready_o, int_ready_o, resume_o and branch_vec_o are 0.
- R2: In run mode, a sleep strobe with idle_en_i=1 and clk_sel_i[1]=1 enters idle one cycle later. In idle the CPU clock enable is 0 and the peripheral clock enable is 1. clk_sel_i[0] has no effect.
- R3: In run mode, a sleep strobe with idle_en_i=1 and clk_sel_i[1]=0 is ignored and the CPU clock stays enabled.
- R4: In run mode, a sleep strobe with idle_en_i=0 enters sleep one cycle later. In sleep both clock enables are 0 and the internal oscillator is off.
- R5: pri_osc_en_o is 1 only in run mode with clk_sel_i[1]=0. pri_ready_o goes to 1 after PRI_CYC consecutive enabled cycles. It falls to 0 in the same cycle the enable drops, for example when the internal source is selected.
- R6: The internal oscillator is on when osc_freq_i is non-zero or int_src_i=1, except in sleep. int_ready_o goes to 1 after STAB_CYC consecutive on-cycles and stays 1 across entry to idle. It falls to 0 in the same cycle the oscillator turns off.
- R7: From idle or sleep, a wake starts when some irq_flag_i bit is 1 and its irq_en_i bit is also 1, or when wdt_timeout_i=1. A flag whose enable is 0 does not wake the core.
- R8: After the cycle in which a wake is sampled, the block spends EXIT_DLY cycles with the CPU clock off and the peripheral clock on. It then re-enables the CPU clock, and resume_o is 1 for exactly that first cycle.
- R9: branch_vec_o goes with resume_o only when the wake included an enabled interrupt and gie_i was 1 at the wake. A watchdog-only wake, or gie_i=0, resumes without it.
- R10: wdt_timeout_i has no effect on this block in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_i | input | 1 | One-cycle strobe: sleep instruction executed |
| idle_en_i | input | 1 | Selects idle (1) or full sleep (0) |
| clk_sel_i | input | 2 | Clock select; bit 1 set selects the internal multiplexer, bit 0 unused |
| osc_freq_i | input | FREQ_W | Internal oscillator frequency field |
| int_src_i | input | 1 | Internal-source select |
| irq_flag_i | input | N_IRQ | Interrupt flags |
| irq_en_i | input | N_IRQ | Per-flag interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_timeout_i | input | 1 | Watchdog time-out |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| pri_ready_o | output | 1 | Primary oscillator ready |
| int_ready_o | output | 1 | Internal oscillator stable |
| resume_o | output | 1 | One-cycle strobe: execution resumes |
| branch_vec_o | output | 1 | Branch to interrupt vector on resume |

## Verification
The bench builds the block with PRI_CYC=6, STAB_CYC=5 and EXIT_DLY=3, with four interrupt lines and a 3-bit frequency field. These short windows let each ready flag be checked in the cycle before it rises and in the cycle it rises. The same holds for the cycle in which the CPU clock returns after a wake. With these values, the restart of the internal oscillator after a sleep wake overlaps the exit delay, so the resume cycle and the ready cycle can both be checked in one run. The run covers interrupt-driven and watchdog-driven wakes, with and without the global enable.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_EXIT  = 2'd3
  } pm_state_e;

  // Width able to hold the value v (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/pms_downcnt.sv
// Reloads while run_i is low; counts down to zero while run_i is high.
module pms_downcnt #(
  parameter int unsigned LOAD_VAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned W = pwr_mode_pkg::cnt_bits(LOAD_VAL);
  localparam logic [W-1:0] LOAD_W = W'(LOAD_VAL);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != LOAD_W);
      cnt_d  = LOAD_W;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD_W;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/pms_wake_eval.sv
module pms_wake_eval #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             wdt_timeout_i,
  output logic             irq_hit_o,
  output logic             wake_o
);
  logic [N_IRQ-1:0] hit;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign hit[g] = irq_flag_i[g] & irq_en_i[g];
  end

  assign irq_hit_o = |hit;
  assign wake_o    = irq_hit_o | wdt_timeout_i;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int unsigned N_IRQ    = 4,
  parameter int unsigned FREQ_W   = 3,
  parameter int unsigned PRI_CYC  = 16,
  parameter int unsigned STAB_CYC = 8,
  parameter int unsigned EXIT_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              idle_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic [FREQ_W-1:0] osc_freq_i,
  input  logic              int_src_i,
  input  logic [N_IRQ-1:0]  irq_flag_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic              gie_i,
  input  logic              wdt_timeout_i,
  output logic              cpu_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              pri_osc_en_o,
  output logic              pri_ready_o,
  output logic              int_ready_o,
  output logic              resume_o,
  output logic              branch_vec_o
);
  import pwr_mode_pkg::*;

  localparam int unsigned EXIT_LOAD = (EXIT_DLY > 0) ? EXIT_DLY - 1 : 0;

  pm_state_e state_q, state_d;
  logic      vec_q, vec_d;
  logic      resume_q, resume_d;
  logic      branch_q, branch_d;
  logic      irq_hit, wake;
  logic      exit_done;
  logic      int_osc_on;
  logic      in_exit;

  // Wake condition
  pms_wake_eval #(.N_IRQ(N_IRQ)) u_wake (
    .irq_flag_i   (irq_flag_i),
    .irq_en_i     (irq_en_i),
    .wdt_timeout_i(wdt_timeout_i),
    .irq_hit_o    (irq_hit),
    .wake_o       (wake)
  );

  // Oscillator handshakes and exit delay, one down-counter each
  assign pri_osc_en_o = (state_q == PM_RUN) && !clk_sel_i[1];
  assign int_osc_on   = ((|osc_freq_i) || int_src_i) && (state_q != PM_SLEEP);
  assign in_exit      = (state_q == PM_EXIT);

  pms_downcnt #(.LOAD_VAL(PRI_CYC)) u_pri_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(pri_osc_en_o), .done_o(pri_ready_o)
  );

  pms_downcnt #(.LOAD_VAL(STAB_CYC)) u_int_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(int_osc_on), .done_o(int_ready_o)
  );

  pms_downcnt #(.LOAD_VAL(EXIT_LOAD)) u_exit_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(in_exit), .done_o(exit_done)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    vec_d    = vec_q;
    resume_d = 1'b0;
    branch_d = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (sleep_i) begin
          if (!idle_en_i)        state_d = PM_SLEEP;
          else if (clk_sel_i[1]) state_d = PM_IDLE;
        end
      end
      PM_IDLE, PM_SLEEP: begin
        if (wake) begin
          state_d = PM_EXIT;
          vec_d   = irq_hit && gie_i;
        end
      end
      PM_EXIT: begin
        if (exit_done) begin
          state_d  = PM_RUN;
          resume_d = 1'b1;
          branch_d = vec_q;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PM_RUN;
      vec_q    <= 1'b0;
      resume_q <= 1'b0;
      branch_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      vec_q    <= vec_d;
      resume_q <= resume_d;
      branch_q <= branch_d;
    end
  end

  assign cpu_clk_en_o    = (state_q == PM_RUN);
  assign periph_clk_en_o = (state_q != PM_SLEEP);
  assign resume_o        = resume_q;
  assign branch_vec_o    = branch_q;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int unsigned FREQ_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_i,
  input logic              idle_en_i,
  input logic [1:0]        clk_sel_i,
  input logic [FREQ_W-1:0] osc_freq_i,
  input logic              int_src_i,
  input logic              wdt_timeout_i,
  input logic              cpu_clk_en_o,
  input logic              periph_clk_en_o,
  input logic              pri_osc_en_o,
  input logic              pri_ready_o,
  input logic              int_ready_o,
  input logic              resume_o,
  input logic              branch_vec_o
);
  assert_cpu_off_when_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en_o |-> !cpu_clk_en_o);

  assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && sleep_i && !idle_en_i) |=> !periph_clk_en_o);

  assert_idle_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && sleep_i && idle_en_i && !clk_sel_i[1]) |=> cpu_clk_en_o);

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && sleep_i && idle_en_i && clk_sel_i[1]) |=> (!cpu_clk_en_o && periph_clk_en_o));

  assert_pri_en_run_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pri_osc_en_o |-> (cpu_clk_en_o && !clk_sel_i[1]));

  assert_pri_ready_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pri_ready_o |-> pri_osc_en_o);

  assert_int_ready_needs_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_ready_o |-> ((|osc_freq_i) || int_src_i));

  assert_wdt_wakes_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_clk_en_o && wdt_timeout_i) |=> periph_clk_en_o);

  assert_resume_on_cpu_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en_o) |-> resume_o);

  assert_resume_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);

  assert_branch_with_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    branch_vec_o |-> resume_o);

  assert_wdt_no_effect_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && !sleep_i && wdt_timeout_i) |=> (cpu_clk_en_o && !resume_o));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sleep_i        (sleep_i),
  .idle_en_i      (idle_en_i),
  .clk_sel_i      (clk_sel_i),
  .osc_freq_i     (osc_freq_i),
  .int_src_i      (int_src_i),
  .wdt_timeout_i  (wdt_timeout_i),
  .cpu_clk_en_o   (cpu_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o),
  .pri_osc_en_o   (pri_osc_en_o),
  .pri_ready_o    (pri_ready_o),
  .int_ready_o    (int_ready_o),
  .resume_o       (resume_o),
  .branch_vec_o   (branch_vec_o)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int N_IRQ = 4;
  localparam int FREQ_W = 3;
  localparam int PRI = 6;
  localparam int STAB = 5;
  localparam int EXIT = 3;

  // observed vector bit order: cpu, periph, pri_en, pri_rdy, int_rdy, resume, branch
  localparam logic [6:0] M_ALL = 7'h7F;
  localparam logic [6:0] M_CPU = 7'b1000000;
  localparam logic [6:0] M_PER = 7'b0100000;
  localparam logic [6:0] M_PEN = 7'b0010000;
  localparam logic [6:0] M_PRD = 7'b0001000;
  localparam logic [6:0] M_IRD = 7'b0000100;
  localparam logic [6:0] M_RES = 7'b0000010;
  localparam logic [6:0] M_BR  = 7'b0000001;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              sleep_i, idle_en_i, int_src_i, gie_i, wdt_timeout_i;
  logic [1:0]        clk_sel_i;
  logic [FREQ_W-1:0] osc_freq_i;
  logic [N_IRQ-1:0]  irq_flag_i, irq_en_i;
  logic cpu_clk_en_o, periph_clk_en_o, pri_osc_en_o, pri_ready_o;
  logic int_ready_o, resume_o, branch_vec_o;

  pwr_mode_seq #(
    .N_IRQ(N_IRQ), .FREQ_W(FREQ_W), .PRI_CYC(PRI), .STAB_CYC(STAB), .EXIT_DLY(EXIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .idle_en_i(idle_en_i),
    .clk_sel_i(clk_sel_i), .osc_freq_i(osc_freq_i), .int_src_i(int_src_i),
    .irq_flag_i(irq_flag_i), .irq_en_i(irq_en_i), .gie_i(gie_i),
    .wdt_timeout_i(wdt_timeout_i), .cpu_clk_en_o(cpu_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o), .pri_osc_en_o(pri_osc_en_o),
    .pri_ready_o(pri_ready_o), .int_ready_o(int_ready_o), .resume_o(resume_o),
    .branch_vec_o(branch_vec_o)
  );

  wire [6:0] obs = {cpu_clk_en_o, periph_clk_en_o, pri_osc_en_o, pri_ready_o,
                    int_ready_o, resume_o, branch_vec_o};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    string      req;
    logic [6:0] mask;
    logic [6:0] val;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // driver side: queue an expectation dly cycles from now
  task automatic expect_at(input int dly, input string req,
                           input logic [6:0] m, input logic [6:0] v);
    item_t it;
    it.at = cyc + dly; it.req = req; it.mask = m; it.val = v;
    sb.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        n_cmp++;
        if ((obs & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
          n_bad++;
          $display("FAIL %s cycle %0d actual %b expected %b (mask %b)",
                   sb[i].req, cyc, obs & sb[i].mask, sb[i].val & sb[i].mask, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..R10 actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_i = 1'b0; idle_en_i = 1'b0; clk_sel_i = 2'b00;
    osc_freq_i = '0; int_src_i = 1'b0; irq_flag_i = '0; irq_en_i = '0;
    gie_i = 1'b0; wdt_timeout_i = 1'b0;
    tick(2);
    // R1 reset state
    expect_at(0, "R1", M_ALL, 7'b1110000);
    tick(1);
    rst_n = 1'b1;
    expect_at(1, "R1", M_ALL, 7'b1110000);
    // R5 primary ready after PRI enabled cycles
    expect_at(PRI - 1, "R5", M_PRD, 7'b0);
    expect_at(PRI, "R5", M_PRD, M_PRD);
    tick(PRI + 1);

    // R6 internal oscillator stabilises
    osc_freq_i = 3'd3;
    expect_at(STAB - 1, "R6", M_IRD, 7'b0);
    expect_at(STAB, "R6", M_IRD, M_IRD);
    tick(STAB + 1);

    // R3 idle refused while primary selected
    idle_en_i = 1'b1; sleep_i = 1'b1;
    expect_at(1, "R3", M_CPU | M_PER, 7'b1100000);
    expect_at(2, "R3", M_CPU, M_CPU);
    tick(1); sleep_i = 1'b0; tick(2);

    // R5 switching to internal drops primary enable and ready at once
    clk_sel_i = 2'b11;
    expect_at(0, "R5", M_PEN | M_PRD | M_CPU, M_CPU);
    tick(1);

    // R2 idle entry, clk_sel bit 0 set but ignored; R6 ready held
    sleep_i = 1'b1;
    expect_at(1, "R2", M_ALL, 7'b0100100);
    tick(1); sleep_i = 1'b0;

    // R7 flag without enable does not wake
    gie_i = 1'b1; irq_flag_i = 4'b0010; irq_en_i = 4'b0100;
    expect_at(1, "R7", M_CPU | M_PER, M_PER);
    expect_at(3, "R7", M_CPU | M_PER, M_PER);
    tick(3);

    // R7/R8/R9 enabled interrupt wakes with branch
    irq_flag_i = 4'b0100;
    expect_at(1, "R8", M_CPU | M_PER | M_RES, M_PER);
    expect_at(EXIT, "R8", M_CPU | M_PER | M_RES, M_PER);
    expect_at(EXIT + 1, "R9", M_CPU | M_RES | M_BR, 7'b1000011);
    expect_at(EXIT + 2, "R8", M_CPU | M_RES | M_BR, M_CPU);
    tick(1); irq_flag_i = '0; tick(EXIT + 2);

    // R4 full sleep
    idle_en_i = 1'b0; sleep_i = 1'b1;
    expect_at(1, "R4", M_ALL, 7'b0);
    expect_at(2, "R4", M_PER | M_CPU, 7'b0);
    tick(1); sleep_i = 1'b0; tick(2);

    // R7/R9 watchdog wake, no branch; R6 internal restarts
    wdt_timeout_i = 1'b1;
    expect_at(1, "R7", M_CPU | M_PER, M_PER);
    expect_at(EXIT + 1, "R9", M_CPU | M_RES | M_BR, 7'b1000010);
    expect_at(STAB, "R6", M_IRD, 7'b0);
    expect_at(STAB + 1, "R6", M_IRD, M_IRD);
    tick(1); wdt_timeout_i = 1'b0; tick(STAB + 2);

    // R9 interrupt wake from idle with gie clear
    idle_en_i = 1'b1; sleep_i = 1'b1;
    tick(1); sleep_i = 1'b0; gie_i = 1'b0;
    irq_flag_i = 4'b0001; irq_en_i = 4'b0001;
    expect_at(EXIT + 1, "R9", M_CPU | M_RES | M_BR, 7'b1000010);
    tick(1); irq_flag_i = '0; tick(EXIT + 2);

    // R10 watchdog in run ignored
    wdt_timeout_i = 1'b1;
    expect_at(1, "R10", M_CPU | M_RES, M_CPU);
    expect_at(2, "R10", M_CPU | M_PER | M_RES, 7'b1100000);
    tick(2); wdt_timeout_i = 1'b0;

    // R6 both sources clear keeps flag low, then int_src alone enables
    osc_freq_i = '0; int_src_i = 1'b0;
    expect_at(0, "R6", M_IRD, 7'b0);
    expect_at(STAB + 2, "R6", M_IRD, 7'b0);
    tick(STAB + 3);
    int_src_i = 1'b1;
    expect_at(STAB - 1, "R6", M_IRD, 7'b0);
    expect_at(STAB, "R6", M_IRD, M_IRD);
    tick(STAB + 1);

    // R5 back to primary: restart of ready window
    clk_sel_i = 2'b00;
    expect_at(0, "R5", M_PEN | M_PRD, M_PEN);
    expect_at(PRI - 1, "R5", M_PRD, 7'b0);
    expect_at(PRI, "R5", M_PRD, M_PRD);
    tick(PRI + 2);

    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL R1..R10 pending checks actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule